// File: doc/BRIEF.md
# Serial Sigma-Delta Conversion Word Reader

This block is the host side of a three-wire link to a sigma-delta converter. While `enable_i` is high it drives the active-low chip select low and watches the converter's data line. A high-to-low transition on that line means a conversion has finished. The block then issues exactly 24 serial clocks and shifts in one 24-bit word, taking the most significant bit first.

Each word begins with four header bits, counted from 1 in shift order. Bit 1 must read 0. Bit 2 is the overrange flag and bit 3 is the oscillation flag. Bit 4 must read 0. The data field fills the remaining 20 bits.

A mode input selects one of two resolutions:
- **20-bit mode:** all 20 remaining bits are the result.
- **16-bit mode:** four padding zeros come first, then a 16-bit result.

The block returns the result right-aligned and zero-extended to 20 bits, together with both flags and a framing-error bit, as a one-cycle valid pulse.

The serial clock comes from a divider whose setting is an input. A wait-for-conversion timeout releases chip select if no falling edge arrives in time. After each word the block goes straight back to waiting for the next falling edge, without releasing chip select.

Top module: `sdr_word_reader`

## Requirements
- R1: During and right after reset, `adc_cs_n_o` is 1, and `adc_sclk_o`, `valid_o` and `timeout_o` are 0.
- R2: Chip select follows `enable_i` outside a frame. While `enable_i` is 0 and no frame is in progress, `adc_cs_n_o` stays 1, no serial clock is issued and the data line is ignored. One clock after `enable_i` rises, `adc_cs_n_o` is 0. While waiting for a conversion, dropping `enable_i` returns `adc_cs_n_o` to 1 one clock later.
- R3: A high-to-low transition of `adc_sdo_i` while waiting starts a frame of exactly 24 rising edges of `adc_sclk_o`. `adc_sclk_o` is 0 whenever `adc_cs_n_o` is 1.
- R4: Within a frame, every high phase of `adc_sclk_o` lasts exactly `div_i` clocks. Every low phase between two serial clock pulses also lasts exactly `div_i` clocks. `div_i` must be at least 3.
- R5: `ovr_o` equals word bit 2 and `osc_o` equals word bit 3 of the same word. Neither is held over: a word whose bit 2 is 0 reports `ovr_o` = 0 even directly after an overranged word.
- R6: With `wide_i` = 1, `data_o` equals the last 20 bits of the word, first received bit in `data_o[19]`.
- R7: With `wide_i` = 0, `data_o[15:0]` equals the last 16 bits of the word and `data_o[19:16]` is 0.
- R8: `ferr_o` is 1 when bit 1 or bit 4 reads 1, or when `wide_i` = 0 and any of bits 5 to 8 reads 1. The data is still delivered unchanged.
- R9: After chip select goes low, if no falling edge arrives within `tmo_lim_i` clocks (`tmo_lim_i` ≥ 1), two things happen in the same clock: `timeout_o` pulses for exactly one clock and `adc_cs_n_o` returns to 1. This is exactly `tmo_lim_i` clocks after chip select fell. `timeout_o` and `valid_o` are never high together.
- R10: `valid_o` is high for exactly one clock. It rises in the same clock as the 24th falling edge of `adc_sclk_o`. `adc_cs_n_o` then stays 0 while `enable_i` is 1, ready for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Keep chip select asserted and read words |
| wide_i | input | 1 | 1 = 20-bit result, 0 = 16-bit result; latched at frame start |
| div_i | input | DIV_W | Serial clock half period in system clocks (≥ 3) |
| tmo_lim_i | input | TMO_W | Wait-for-conversion limit in system clocks (≥ 1) |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock, idles low |
| adc_sdo_i | input | 1 | Serial data from converter |
| data_o | output | WIDE_W | Result, right-aligned, zero-extended |
| ovr_o | output | 1 | Overrange flag of this word |
| osc_o | output | 1 | Oscillation flag of this word |
| ferr_o | output | 1 | A reserved bit read as 1 |
| valid_o | output | 1 | One-cycle pulse: outputs carry a new word |
| timeout_o | output | 1 | One-cycle pulse: wait for conversion expired |

## Verification
Words are applied in both resolutions, and each input pattern separates one pair of possibilities:
- **Spread data patterns** tell the 20-bit and 16-bit field positions apart.
- **The same word read in both modes** shows that bits 5 to 8 are data in one mode and reserved in the other.
- **Overrange words followed by clean ones** expose a latched flag.
- **A set bit 1, bit 4, or one padding bit** each raise the framing error alone, with the data still intact.

Serial clock phase widths are measured at two divider settings. Separate tests cover the exact timeout length and the chip-select response to `enable_i`.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

   localparam int unsigned SDR_FRAME_BITS  = 24;
   localparam int unsigned SDR_WIDE_BITS   = 20;
   localparam int unsigned SDR_NARROW_BITS = 16;
   localparam int unsigned SDR_HDR_BITS    = 4;

   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_ARM   = 2'd1,
      RD_SHIFT = 2'd2
   } rd_state_e;

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sdr_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdr_sclk_gen.sv
module sdr_sclk_gen #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned FRAME_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             last_o
);

   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

   logic [DIV_W-1:0] ph_q;
   logic [CNT_W-1:0] nbit_q;
   logic             sclk_q;
   logic             tick;

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("sdr_sclk_gen: DIV_W must be at least 2");
      end
   endgenerate

   // phase boundary: the serial clock toggles at this edge
   assign tick   = run_i && (ph_q == (div_i - DIV_W'(1)));
   assign rise_o = tick && !sclk_q;
   assign last_o = tick && sclk_q && (nbit_q == CNT_W'(FRAME_W - 1));
   assign sclk_o = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         nbit_q <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         ph_q   <= '0;
         nbit_q <= '0;
         sclk_q <= 1'b0;
      end else if (tick) begin
         ph_q   <= '0;
         sclk_q <= !sclk_q;
         if (sclk_q) nbit_q <= nbit_q + CNT_W'(1);
      end else begin
         ph_q <= ph_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/sdr_field_decode.sv
module sdr_field_decode #(
   parameter int unsigned FRAME_W  = 24,
   parameter int unsigned WIDE_W   = 20,
   parameter int unsigned NARROW_W = 16
) (
   input  logic [FRAME_W-1:0] word_i,
   input  logic               wide_i,
   output logic [WIDE_W-1:0]  data_o,
   output logic               ovr_o,
   output logic               osc_o,
   output logic               ferr_o
);

   localparam int unsigned HDR_W = FRAME_W - WIDE_W;
   localparam int unsigned PAD_W = WIDE_W - NARROW_W;

   logic              hdr_bad;
   logic              pad_bad;
   logic [WIDE_W-1:0] narrow_data;

   generate
      if (HDR_W != 4) begin : g_bad_hdr
         $error("sdr_field_decode: header must be four bits");
      end
      if (PAD_W > 0) begin : g_pad
         assign narrow_data = {{PAD_W{1'b0}}, word_i[NARROW_W-1:0]};
         assign pad_bad     = |word_i[WIDE_W-1:NARROW_W];
      end else begin : g_nopad
         assign narrow_data = word_i[WIDE_W-1:0];
         assign pad_bad     = 1'b0;
      end
   endgenerate

   // header in shift order: zero, overrange, oscillation, zero
   assign hdr_bad = word_i[FRAME_W-1] | word_i[FRAME_W-4];
   assign ovr_o   = word_i[FRAME_W-2];
   assign osc_o   = word_i[FRAME_W-3];
   assign data_o  = wide_i ? word_i[WIDE_W-1:0] : narrow_data;
   assign ferr_o  = hdr_bad | (!wide_i & pad_bad);

endmodule

// File: rtl/sdr_word_reader.sv
module sdr_word_reader
   import sdr_pkg::*;
#(
   parameter int unsigned FRAME_W     = SDR_FRAME_BITS,
   parameter int unsigned WIDE_W      = SDR_WIDE_BITS,
   parameter int unsigned NARROW_W    = SDR_NARROW_BITS,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned TMO_W       = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              wide_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [TMO_W-1:0]  tmo_lim_i,
   output logic              adc_cs_n_o,
   output logic              adc_sclk_o,
   input  logic              adc_sdo_i,
   output logic [WIDE_W-1:0] data_o,
   output logic              ovr_o,
   output logic              osc_o,
   output logic              ferr_o,
   output logic              valid_o,
   output logic              timeout_o
);

   generate
      if (FRAME_W != WIDE_W + SDR_HDR_BITS) begin : g_bad_frame
         $error("sdr_word_reader: FRAME_W must equal WIDE_W plus header");
      end
      if (NARROW_W > WIDE_W) begin : g_bad_narrow
         $error("sdr_word_reader: NARROW_W exceeds WIDE_W");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("sdr_word_reader: TMO_W must be at least 1");
      end
   endgenerate

   rd_state_e         state_q, state_d;
   logic [TMO_W-1:0]  wait_cnt_q;
   logic [FRAME_W-1:0] shreg_q;
   logic              wide_q;
   logic              sdo_s, sdo_prev_q, sdo_fall;
   logic              cs_n_q;
   logic              sclk_rise, sclk_last;
   logic              tmo_hit;
   logic [WIDE_W-1:0] dec_data;
   logic              dec_ovr, dec_osc, dec_ferr;
   logic [WIDE_W-1:0] data_q;
   logic              ovr_q, osc_q, ferr_q, valid_q, timeout_q;

   sdr_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sdo_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_sdo_i),
      .q_o   (sdo_s)
   );

   sdr_sclk_gen #(
      .DIV_W   (DIV_W),
      .FRAME_W (FRAME_W)
   ) i_sclk_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == RD_SHIFT),
      .div_i  (div_i),
      .sclk_o (adc_sclk_o),
      .rise_o (sclk_rise),
      .last_o (sclk_last)
   );

   sdr_field_decode #(
      .FRAME_W  (FRAME_W),
      .WIDE_W   (WIDE_W),
      .NARROW_W (NARROW_W)
   ) i_decode (
      .word_i (shreg_q),
      .wide_i (wide_q),
      .data_o (dec_data),
      .ovr_o  (dec_ovr),
      .osc_o  (dec_osc),
      .ferr_o (dec_ferr)
   );

   assign sdo_fall = sdo_prev_q & ~sdo_s;
   assign tmo_hit  = (wait_cnt_q == (tmo_lim_i - TMO_W'(1)));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RD_IDLE: begin
            if (enable_i) state_d = RD_ARM;
         end
         RD_ARM: begin
            if (!enable_i)     state_d = RD_IDLE;
            else if (sdo_fall) state_d = RD_SHIFT;
            else if (tmo_hit)  state_d = RD_IDLE;
         end
         RD_SHIFT: begin
            if (sclk_last) state_d = enable_i ? RD_ARM : RD_IDLE;
         end
         default: state_d = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RD_IDLE;
         cs_n_q     <= 1'b1;
         wait_cnt_q <= '0;
         shreg_q    <= '0;
         wide_q     <= 1'b0;
         sdo_prev_q <= 1'b1;
         data_q     <= '0;
         ovr_q      <= 1'b0;
         osc_q      <= 1'b0;
         ferr_q     <= 1'b0;
         valid_q    <= 1'b0;
         timeout_q  <= 1'b0;
      end else begin
         state_q    <= state_d;
         cs_n_q     <= (state_d == RD_IDLE);
         sdo_prev_q <= sdo_s;
         valid_q    <= 1'b0;
         timeout_q  <= 1'b0;

         if (state_q != RD_ARM) wait_cnt_q <= '0;
         else                   wait_cnt_q <= wait_cnt_q + TMO_W'(1);

         if (state_q == RD_ARM && enable_i && !sdo_fall && tmo_hit)
            timeout_q <= 1'b1;

         if (state_q == RD_ARM && sdo_fall)
            wide_q <= wide_i;

         if (sclk_rise)
            shreg_q <= {shreg_q[FRAME_W-2:0], sdo_s};

         if (sclk_last) begin
            valid_q <= 1'b1;
            data_q  <= dec_data;
            ovr_q   <= dec_ovr;
            osc_q   <= dec_osc;
            ferr_q  <= dec_ferr;
         end
      end
   end

   assign adc_cs_n_o = cs_n_q;
   assign data_o     = data_q;
   assign ovr_o      = ovr_q;
   assign osc_o      = osc_q;
   assign ferr_o     = ferr_q;
   assign valid_o    = valid_q;
   assign timeout_o  = timeout_q;

endmodule

// File: rtl/sdr_word_reader_chk.sv
module sdr_word_reader_chk #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned FRAME_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_i,
   input logic             adc_cs_n_o,
   input logic             adc_sclk_o,
   input logic             valid_o,
   input logic             timeout_o
);

   localparam int unsigned RC_W = $clog2(FRAME_W + 1) + 1;

   logic [DIV_W:0] hi_cnt;
   logic [RC_W-1:0] rise_cnt;
   logic           sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         rise_cnt <= '0;
         sclk_d   <= 1'b0;
      end else begin
         sclk_d <= adc_sclk_o;
         if (adc_sclk_o) hi_cnt <= hi_cnt + 1'b1;
         else            hi_cnt <= '0;
         if (valid_o)                      rise_cnt <= '0;
         else if (adc_sclk_o && !sclk_d)   rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n_o |-> !adc_sclk_o);

   // R3
   frame_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rise_cnt == RC_W'(FRAME_W)));

   // R4
   sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sclk_o) |-> (hi_cnt == {1'b0, div_i}));

   // R10
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R9
   timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> adc_cs_n_o);

   // R9
   valid_timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && timeout_o));

   // R9
   timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

endmodule

bind sdr_word_reader sdr_word_reader_chk #(
   .DIV_W   (DIV_W),
   .FRAME_W (FRAME_W)
) i_sdr_word_reader_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .div_i      (div_i),
   .adc_cs_n_o (adc_cs_n_o),
   .adc_sclk_o (adc_sclk_o),
   .valid_o    (valid_o),
   .timeout_o  (timeout_o)
);

// File: tb/test_sdr_word_reader.sv
module test_sdr_word_reader;

   typedef struct packed {
      logic        wide;
      logic [23:0] word;
      logic [19:0] data;
      logic        ovr;
      logic        osc;
      logic        fe;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 24'h0ABCDE, 20'hABCDE, 1'b0, 1'b0, 1'b0},  // R6 plain 20-bit
      '{1'b1, 24'h4FFFFF, 20'hFFFFF, 1'b1, 1'b0, 1'b0},  // R5 overrange
      '{1'b1, 24'h200001, 20'h00001, 1'b0, 1'b1, 1'b0},  // R5 overrange cleared, oscillation
      '{1'b0, 24'h001234, 20'h01234, 1'b0, 1'b0, 1'b0},  // R7 plain 16-bit
      '{1'b0, 24'h60BEEF, 20'h0BEEF, 1'b1, 1'b1, 1'b0},  // R5 R7 both flags
      '{1'b0, 24'h085A5A, 20'h05A5A, 1'b0, 1'b0, 1'b1},  // R8 padding bit set
      '{1'b1, 24'h085A5A, 20'h85A5A, 1'b0, 1'b0, 1'b0},  // R6 same bits are data
      '{1'b1, 24'h112345, 20'h12345, 1'b0, 1'b0, 1'b1},  // R8 bit 4 set
      '{1'b0, 24'h8000FF, 20'h000FF, 1'b0, 1'b0, 1'b1},  // R8 bit 1 set
      '{1'b0, 24'h000000, 20'h00000, 1'b0, 1'b0, 1'b0}   // R5 flags clear
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        wide = 1'b0;
   logic [7:0]  div = 8'd3;
   logic [19:0] tmo_lim = 20'd100000;
   logic        sdo = 1'b1;
   logic        cs_n, sclk, ovr, osc, ferr, valid, timeout;
   logic [19:0] data;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sdr_word_reader i_sdr_word_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable),
      .wide_i     (wide),
      .div_i      (div),
      .tmo_lim_i  (tmo_lim),
      .adc_cs_n_o (cs_n),
      .adc_sclk_o (sclk),
      .adc_sdo_i  (sdo),
      .data_o     (data),
      .ovr_o      (ovr),
      .osc_o      (osc),
      .ferr_o     (ferr),
      .valid_o    (valid),
      .timeout_o  (timeout)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // converter model: announce, then present one bit per serial clock
   task automatic run_word(input vec_t v, input int dv, input string tag);
      int   rises = 0, falls = 0, hi_w = 0, lo_w = 0, guard = 0;
      logic prev = 1'b0;
      bit   wbad = 1'b0;
      wide = v.wide;
      while (cs_n !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
      sdo = 1'b1;
      repeat (4) @(negedge clk);
      sdo = 1'b0;
      @(negedge clk);
      sdo = v.word[23];
      guard = 0;
      while (falls < 24 && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (sclk && !prev) begin
            rises++;
            if (falls > 0 && lo_w != dv) wbad = 1'b1;
            hi_w = 1;
            lo_w = 0;
         end else if (!sclk && prev) begin
            if (hi_w != dv) wbad = 1'b1;
            falls++;
            hi_w = 0;
            lo_w = 1;
            if (falls < 24) sdo = v.word[23 - falls];
         end else if (sclk) begin
            hi_w++;
         end else begin
            lo_w++;
         end
         prev = sclk;
      end
      check({"R3 rises ", tag}, 32'(rises), 32'd24);
      check({"R4 phase widths ", tag}, {31'd0, wbad}, 32'd0);
      check({"R10 valid at last fall ", tag}, {31'd0, valid}, 32'd1);
      check({"R6/R7 data ", tag}, {12'd0, data}, {12'd0, v.data});
      check({"R5 ovr ", tag}, {31'd0, ovr}, {31'd0, v.ovr});
      check({"R5 osc ", tag}, {31'd0, osc}, {31'd0, v.osc});
      check({"R8 ferr ", tag}, {31'd0, ferr}, {31'd0, v.fe});
      sdo = 1'b1;
      @(negedge clk);
      check({"R10 valid single ", tag}, {31'd0, valid}, 32'd0);
      check({"R10 cs held ", tag}, {31'd0, cs_n}, 32'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cs_n", {31'd0, cs_n}, 32'd1);
      check("R1 sclk", {31'd0, sclk}, 32'd0);
      check("R1 valid", {31'd0, valid}, 32'd0);
      check("R1 timeout", {31'd0, timeout}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cs_n after reset", {31'd0, cs_n}, 32'd1);

      // R2 disabled: falling edge on the data line is ignored
      sdo = 1'b0;
      repeat (10) @(negedge clk);
      sdo = 1'b1;
      check("R2 cs_n idle", {31'd0, cs_n}, 32'd1);
      check("R2 no sclk", {31'd0, sclk}, 32'd0);
      check("R2 no valid", {31'd0, valid}, 32'd0);
      repeat (4) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check("R2 cs_n asserts", {31'd0, cs_n}, 32'd0);

      // vector table, back-to-back words with chip select held
      for (int i = 0; i < NV; i++) begin
         run_word(VECS[i], 3, $sformatf("vec%0d", i));
      end

      // R4 other divider setting
      div = 8'd7;
      run_word(VECS[0], 7, "div7");
      run_word(VECS[3], 7, "div7 narrow");
      div = 8'd3;

      // R2 dropping enable while waiting
      enable = 1'b0;
      @(negedge clk);
      check("R2 cs_n release", {31'd0, cs_n}, 32'd1);

      // R9 timeout exactly tmo_lim clocks after cs falls
      tmo_lim = 20'd50;
      sdo = 1'b1;
      repeat (3) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      cnt = 0;
      while (cs_n === 1'b0 && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      check("R9 cs low length", 32'(cnt), 32'd50);
      check("R9 timeout pulse", {31'd0, timeout}, 32'd1);
      check("R9 cs released", {31'd0, cs_n}, 32'd1);
      @(negedge clk);
      check("R9 timeout single", {31'd0, timeout}, 32'd0);
      check("R9 rearm", {31'd0, cs_n}, 32'd0);

      // word after a timeout still reads correctly
      tmo_lim = 20'd100000;
      run_word(VECS[1], 3, "after timeout");

      enable = 1'b0;
      repeat (3) @(negedge clk);
      summary();
   end

endmodule